// File: doc/BRIEF.md
# Latched Protection Fault Supervisor

This block decides how a synchronous step-down controller reacts to protection events. It watches an overcurrent comparator, undervoltage and overvoltage comparators on the feedback node, and a pair of temperature comparators. For each event it applies that event's own qualification rule. Overcurrent and undervoltage must be seen on a run of consecutive switching cycles. Overvoltage must hold without a break for a blanking time counted in clock cycles. Temperature uses a two-level hysteresis. The result drives three gate-control overrides, which the PWM stage and gate drivers obey: force the high side off, force the low side on, and force both switches off.

Overcurrent and undervoltage faults latch and hold both switches off. An overvoltage fault also latches, but it keeps the high side off and runs a hysteretic clamp on the low side, so that the output is pulled down without being driven far below regulation. The thermal fault does not latch: it releases once the die has cooled below the lower threshold. Latched faults are cleared only by a power-on or enable reset pulse. A single summary output reports whether any fault is latched.

Top module: `prot_fault_sup`

## Requirements
- R1: While `oc_en` is 1, `hs_off` is 1 in any clock cycle in which `oc_flag` is 1. From the next clock edge on, it stays 1 until a `cyc_tick` edge at which `oc_flag` is 0.
- R2: With `oc_en` at 1, `oc_flag` high at 16 consecutive `cyc_tick` edges (OC_CYCLES) sets `oc_latched` and `both_off` from the edge of the 16th tick. At 15 such ticks neither is set.
- R3: A `cyc_tick` edge at which the qualifying flag is low restarts the consecutive count, for overcurrent and for undervoltage alike. A fresh full run is then needed to latch.
- R4: While `oc_en` is 0, overcurrent neither counts toward a latch nor truncates the high side: `hs_off` and `oc_latched` remain 0.
- R5: `uv_flag` high at 8 consecutive `cyc_tick` edges (UV_CYCLES) sets `uv_latched` and `both_off`. At 7 such ticks neither is set.
- R6: `ov_flag` high on OV_BLANK_CLKS consecutive clock edges sets `ov_latched`. Any clock edge with `ov_flag` low restarts the blanking count.
- R7: While `ov_latched` is 1, `hs_off` is 1. `ls_on` is 1 from the latch edge, goes to 0 after an edge with `uv_flag` high, and returns to 1 after an edge with `uv_rel_flag` high and `uv_flag` low. Otherwise it holds its value. `ls_on` and `both_off` are never 1 together.
- R8: `oc_latched`, `uv_latched` and `ov_latched` stay set whatever the comparator inputs do. All three clear after a clock edge with `por_pulse` at 1.
- R9: `thermal_active` becomes 1 after an edge with `temp_hot` at 1. It becomes 0 after an edge with `temp_cool` at 1 and `temp_hot` at 0, and holds otherwise. While it is 1 (and no overvoltage fault is latched), `both_off` is 1. `por_pulse` is not needed to release it.
- R10: While `ov_latched` is 1, `both_off` stays 0 even if other faults are active, and undervoltage ticks do not count toward `uv_latched`.
- R11: `fault_any` is the OR of the three latched bits. After `rst_n` low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_pulse | input | 1 | Power-on / enable reset pulse, clears latched faults |
| cyc_tick | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_flag | input | 1 | Inductor current above the limit |
| oc_en | input | 1 | Overcurrent protection enabled by configuration |
| uv_flag | input | 1 | Feedback below the lower undervoltage level |
| uv_rel_flag | input | 1 | Feedback above the upper undervoltage level |
| ov_flag | input | 1 | Feedback above the overvoltage level |
| temp_hot | input | 1 | Die above the upper temperature threshold |
| temp_cool | input | 1 | Die below the lower temperature threshold |
| hs_off | output | 1 | Force the high-side switch off |
| ls_on | output | 1 | Force the low-side switch on |
| both_off | output | 1 | Force both switches off |
| oc_latched | output | 1 | Overcurrent fault latched |
| uv_latched | output | 1 | Undervoltage fault latched |
| ov_latched | output | 1 | Overvoltage fault latched |
| thermal_active | output | 1 | Thermal shutdown in force |
| fault_any | output | 1 | Any fault latched |

## Verification
Every latch and the clamp are registered, so each of them is due on the clock edge that completes its rule. That edge is the edge of the 16th or 8th qualifying tick, the last edge of the overvoltage blanking run, or the edge that sees the clamp or thermal condition. The high-side truncation is the one exception: it follows `oc_flag` within the same cycle. The bench drives its inputs on falling edges and samples on the following falling edge, so every registered result is read half a clock after the edge that made it. For the off-by-one cases it stops the run one tick or one clock short of the limit and reads the latch there. It then adds the last tick or clock and reads the latch again.

// File: rtl/psup_pkg.sv
// Package for the protection fault supervisor.
// Holds the gate-override mode, the override bundle, and the decode between them.
package psup_pkg;

    typedef enum logic [2:0] {
        GM_RUN        = 3'd0,
        GM_TRUNC      = 3'd1,
        GM_CLAMP_LS   = 3'd2,
        GM_CLAMP_IDLE = 3'd3,
        GM_SHUTDOWN   = 3'd4
    } gate_mode_e;

    typedef struct packed {
        logic hs_off;
        logic ls_on;
        logic both_off;
    } gate_ovr_t;

    // Maps a gate mode to the three override lines.
    function automatic gate_ovr_t decode_mode(gate_mode_e m);
        gate_ovr_t o;
        o = '0;
        case (m)
            GM_TRUNC:      o.hs_off = 1'b1;
            GM_CLAMP_LS:   begin o.hs_off = 1'b1; o.ls_on = 1'b1; end
            GM_CLAMP_IDLE: o.hs_off = 1'b1;
            GM_SHUTDOWN:   begin o.hs_off = 1'b1; o.both_off = 1'b1; end
            default:       o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/psup_consec_qual.sv
// Consecutive switching-cycle qualifier.
// Counts cycle ticks at which cond is high and latches after RUN_LEN of them in a row.
// A tick with cond low restarts the count. While arm is low the count is held at zero.
// Assumes tick is a one-clock pulse; clr is the synchronous fault-clear pulse.
module psup_consec_qual #(
    parameter int unsigned RUN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic tick,
    input  logic cond,
    output logic latched
);
    localparam int unsigned CW   = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          lat_q;

    // Run counter and sticky latch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            lat_q <= 1'b0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!cond) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                lat_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign latched = lat_q;

    // R8
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr) |=> latched);

    // R2
    lat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(tick && cond && arm));

endmodule

// File: rtl/psup_ov_clamp.sv
// Overvoltage qualifier and low-side clamp.
// Latches after ov_flag has held for BLANK_CLKS clock edges in a row; a low edge restarts the count.
// Once latched, the low side is pulled on and released in a hysteretic way:
// it turns off when feedback falls below the lower undervoltage level,
// and turns on again when feedback rises above the upper undervoltage level.
module psup_ov_clamp #(
    parameter int unsigned BLANK_CLKS = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ov_flag,
    input  logic uv_flag,
    input  logic uv_rel_flag,
    output logic ov_lat,
    output logic clamp_on
);
    localparam int unsigned BW   = (BLANK_CLKS > 1) ? $clog2(BLANK_CLKS) : 1;
    localparam logic [BW-1:0] LAST = BW'(BLANK_CLKS - 1);

    logic [BW-1:0] blank_q;
    logic          lat_q;
    logic          clamp_q;

    // Blanking counter and overvoltage latch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            blank_q <= '0;
            lat_q   <= 1'b0;
        end else if (!ov_flag) begin
            blank_q <= '0;
        end else if (blank_q == LAST) begin
            lat_q <= 1'b1;
        end else begin
            blank_q <= blank_q + 1'b1;
        end
    end

    // Hysteretic low-side clamp state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            clamp_q <= 1'b0;
        end else if (!lat_q) begin
            clamp_q <= ov_flag && (blank_q == LAST);
        end else if (uv_flag) begin
            clamp_q <= 1'b0;
        end else if (uv_rel_flag) begin
            clamp_q <= 1'b1;
        end
    end

    assign ov_lat   = lat_q;
    assign clamp_on = clamp_q;

    // R6
    ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_lat) |-> $past(ov_flag));

    // R7
    clamp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_lat && uv_flag && !clr) |=> !clamp_on);

    // R7
    clamp_only_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_on |-> ov_lat);

endmodule

// File: rtl/psup_thermal.sv
// Thermal shutdown with two-threshold hysteresis.
// Set while the die is above the upper threshold, and released only once it is below the lower one.
// If both flags are seen at once, the hot flag wins. The state is not latched and ignores the fault-clear pulse.
module psup_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic active
);
    logic act_q;

    // Hysteresis state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (temp_hot) begin
            act_q <= 1'b1;
        end else if (temp_cool) begin
            act_q <= 1'b0;
        end
    end

    assign active = act_q;

    // R9
    therm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot |=> active);

    // R9
    therm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !temp_cool) |=> active);

endmodule

// File: rtl/prot_fault_sup.sv
// Protection fault supervisor for a synchronous step-down controller.
// Qualifies overcurrent, undervoltage, overvoltage and thermal events, each by its own rule,
// and picks one gate-override mode. The priority order is overvoltage clamp, then shutdown,
// then per-cycle truncation, then normal run.
// Assumes cyc_tick is a one-clock pulse per switching cycle and that the comparator flags are
// already synchronous to clk.
module prot_fault_sup
    import psup_pkg::*;
#(
    parameter int unsigned OC_CYCLES  = 16,
    parameter int unsigned UV_CYCLES  = 8,
    parameter int unsigned OV_BLANK_CLKS = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_pulse,
    input  logic cyc_tick,
    input  logic oc_flag,
    input  logic oc_en,
    input  logic uv_flag,
    input  logic uv_rel_flag,
    input  logic ov_flag,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic hs_off,
    output logic ls_on,
    output logic both_off,
    output logic oc_latched,
    output logic uv_latched,
    output logic ov_latched,
    output logic thermal_active,
    output logic fault_any
);
    logic       oc_live;
    logic       trunc_q;
    logic       oc_lat, uv_lat, ov_lat, clamp_on, therm;
    gate_mode_e mode;
    gate_ovr_t  ovr;

    assign oc_live = oc_flag && oc_en;

    psup_consec_qual #(.RUN_LEN(OC_CYCLES)) u_oc_qual (
        .clk(clk), .rst_n(rst_n), .clr(por_pulse), .arm(oc_en),
        .tick(cyc_tick), .cond(oc_flag), .latched(oc_lat)
    );

    psup_consec_qual #(.RUN_LEN(UV_CYCLES)) u_uv_qual (
        .clk(clk), .rst_n(rst_n), .clr(por_pulse), .arm(!ov_lat),
        .tick(cyc_tick), .cond(uv_flag), .latched(uv_lat)
    );

    psup_ov_clamp #(.BLANK_CLKS(OV_BLANK_CLKS)) u_ov (
        .clk(clk), .rst_n(rst_n), .clr(por_pulse), .ov_flag(ov_flag),
        .uv_flag(uv_flag), .uv_rel_flag(uv_rel_flag),
        .ov_lat(ov_lat), .clamp_on(clamp_on)
    );

    psup_thermal u_therm (
        .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .active(therm)
    );

    // Holds the high-side truncation for the rest of the switching cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || por_pulse) begin
            trunc_q <= 1'b0;
        end else if (oc_live) begin
            trunc_q <= 1'b1;
        end else if (cyc_tick || !oc_en) begin
            trunc_q <= 1'b0;
        end
    end

    // Priority selection of the gate-override mode.
    always_comb begin
        if (ov_lat) begin
            mode = clamp_on ? GM_CLAMP_LS : GM_CLAMP_IDLE;
        end else if (oc_lat || uv_lat || therm) begin
            mode = GM_SHUTDOWN;
        end else if (oc_live || trunc_q) begin
            mode = GM_TRUNC;
        end else begin
            mode = GM_RUN;
        end
    end

    assign ovr            = decode_mode(mode);
    assign hs_off         = ovr.hs_off;
    assign ls_on          = ovr.ls_on;
    assign both_off       = ovr.both_off;
    assign oc_latched     = oc_lat;
    assign uv_latched     = uv_lat;
    assign ov_latched     = ov_lat;
    assign thermal_active = therm;
    assign fault_any      = oc_lat || uv_lat || ov_lat;

    // R10
    ov_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_latched |-> !both_off);

    // R7
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_on && both_off));

    // R1
    trunc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_live && !por_pulse && !ov_latched) |=> (hs_off || !oc_en));

    // R4
    oc_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_en && !oc_latched && !por_pulse) |=> !oc_latched);

endmodule

// File: tb/prot_fault_sup_tb.sv
module prot_fault_sup_tb;
    localparam int BLANK = 40;

    logic clk = 1'b0;
    logic rst_n, por_pulse, cyc_tick, oc_flag, oc_en, uv_flag, uv_rel_flag, ov_flag, temp_hot, temp_cool;
    logic hs_off, ls_on, both_off, oc_latched, uv_latched, ov_latched, thermal_active, fault_any;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prot_fault_sup #(.OC_CYCLES(16), .UV_CYCLES(8), .OV_BLANK_CLKS(BLANK)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .cyc_tick(cyc_tick),
        .oc_flag(oc_flag), .oc_en(oc_en), .uv_flag(uv_flag), .uv_rel_flag(uv_rel_flag),
        .ov_flag(ov_flag), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .hs_off(hs_off), .ls_on(ls_on), .both_off(both_off), .oc_latched(oc_latched),
        .uv_latched(uv_latched), .ov_latched(ov_latched), .thermal_active(thermal_active),
        .fault_any(fault_any)
    );

    // Vector row: [15:8] ticks, [7] oc, [6] uv, [5] oc_en, [4] exp oc, [3] exp uv, [2] exp both_off
    localparam logic [15:0] VEC [6] = '{16'h0FA0, 16'h10B4, 16'h1480, 16'h0760, 16'h086C, 16'h10FC};
    localparam string VREQ [6] = '{"R2", "R2", "R4", "R5", "R5", "R2"};

    task automatic chk(input string req, input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic tick_once();
        cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic por();
        por_pulse = 1'b1;
        @(negedge clk);
        por_pulse = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; por_pulse = 0; cyc_tick = 0; oc_flag = 0; oc_en = 1;
        uv_flag = 0; uv_rel_flag = 0; ov_flag = 0; temp_hot = 0; temp_cool = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", {hs_off, ls_on, both_off, oc_latched, uv_latched, ov_latched, thermal_active, fault_any} == 8'h00,
            1'b1, "all outputs zero after reset");
        rst_n = 1;
        @(negedge clk);

        // Table of tick runs
        for (int i = 0; i < 6; i++) begin
            por();
            oc_flag = VEC[i][7]; uv_flag = VEC[i][6]; oc_en = VEC[i][5];
            for (int t = 0; t < int'(VEC[i][15:8]); t++) tick_once();
            chk(VREQ[i], oc_latched, VEC[i][4], "oc_latched after run");
            chk(VREQ[i], uv_latched, VEC[i][3], "uv_latched after run");
            chk(VREQ[i], both_off, VEC[i][2], "both_off after run");
            if (!VEC[i][5]) chk("R4", hs_off, 1'b0, "hs_off with oc disabled");
            oc_flag = 0; uv_flag = 0; oc_en = 1;
            @(negedge clk);
        end

        // R11 summary with OC latched, then R8 sticky and clear
        por();
        oc_flag = 1;
        for (int t = 0; t < 16; t++) tick_once();
        oc_flag = 0;
        for (int t = 0; t < 5; t++) tick_once();
        chk("R11", fault_any, 1'b1, "fault_any with oc latched");
        chk("R8", oc_latched, 1'b1, "oc latch holds with flag gone");
        por();
        chk("R8", oc_latched, 1'b0, "oc latch cleared by por");
        chk("R8", fault_any, 1'b0, "fault_any cleared by por");

        // R3 clean tick restarts the overcurrent run
        oc_flag = 1;
        for (int t = 0; t < 15; t++) tick_once();
        oc_flag = 0; tick_once();
        oc_flag = 1;
        for (int t = 0; t < 15; t++) tick_once();
        chk("R3", oc_latched, 1'b0, "oc not latched after broken run");
        tick_once();
        chk("R3", oc_latched, 1'b1, "oc latched after fresh 16 run");
        oc_flag = 0;
        por();

        // R3 for undervoltage
        uv_flag = 1;
        for (int t = 0; t < 7; t++) tick_once();
        uv_flag = 0; tick_once();
        uv_flag = 1;
        for (int t = 0; t < 7; t++) tick_once();
        chk("R3", uv_latched, 1'b0, "uv not latched after broken run");
        uv_flag = 0;
        por();

        // R1 per-cycle truncation
        oc_flag = 1;
        #1;
        chk("R1", hs_off, 1'b1, "hs_off same cycle as oc");
        @(negedge clk);
        oc_flag = 0;
        @(negedge clk);
        chk("R1", hs_off, 1'b1, "hs_off held until tick");
        tick_once();
        chk("R1", hs_off, 1'b0, "hs_off released after clean tick");
        por();

        // R6 overvoltage blanking
        ov_flag = 1;
        repeat (BLANK - 1) @(posedge clk);
        @(negedge clk);
        ov_flag = 0;
        chk("R6", ov_latched, 1'b0, "ov not latched one clock short");
        @(negedge clk);
        ov_flag = 1;
        repeat (BLANK) @(posedge clk);
        @(negedge clk);
        chk("R6", ov_latched, 1'b1, "ov latched after full blanking");
        ov_flag = 0;
        // R7 clamp behaviour
        chk("R7", ls_on, 1'b1, "low side on at ov latch");
        chk("R7", hs_off, 1'b1, "high side off in ov fault");
        uv_flag = 1;
        @(negedge clk);
        chk("R7", ls_on, 1'b0, "low side released below uv level");
        // R10 uv ticks blocked during ov fault
        for (int t = 0; t < 10; t++) tick_once();
        chk("R10", uv_latched, 1'b0, "uv not counted during ov fault");
        uv_flag = 0;
        @(negedge clk);
        chk("R7", ls_on, 1'b0, "low side holds between levels");
        uv_rel_flag = 1;
        @(negedge clk);
        chk("R7", ls_on, 1'b1, "low side back on above upper level");
        uv_rel_flag = 0;
        // R10 priority over thermal shutdown
        temp_hot = 1;
        @(negedge clk);
        temp_hot = 0;
        chk("R10", both_off, 1'b0, "ov clamp overrides shutdown");
        chk("R10", ls_on, 1'b1, "clamp kept during thermal");
        temp_cool = 1;
        @(negedge clk);
        temp_cool = 0;
        por();
        chk("R8", ov_latched, 1'b0, "ov latch cleared by por");

        // R9 thermal hysteresis
        temp_hot = 1;
        @(negedge clk);
        temp_hot = 0;
        chk("R9", thermal_active, 1'b1, "thermal set when hot");
        chk("R9", both_off, 1'b1, "both off in thermal");
        repeat (3) @(negedge clk);
        chk("R9", thermal_active, 1'b1, "thermal held between thresholds");
        temp_cool = 1;
        @(negedge clk);
        temp_cool = 0;
        chk("R9", thermal_active, 1'b0, "thermal released when cool");
        chk("R9", fault_any, 1'b0, "thermal not latched");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule